// File: doc/BRIEF.md
# Write-Through Flush Completion Tracker

This block sits beside a write-through L1 data cache and decides when a release flush is complete. The cache pulses one input for every write-through it sends toward the L2 and another for every write acknowledge it receives back. The core pulses a flush request for each line it flushes, together with a flag telling whether that line holds dirty data. The tracker pulses a single flush-done output once every write-through that could precede the release has been acknowledged.

The tracker holds no queue. It keeps a count of unacknowledged write-throughs, a flush-phase counter and a flag that marks an open flush. A completion check is made for each flush of a clean line and for each acknowledge that arrives while the flag is set. The check raises the phase counter by one. If the phase counter then exceeds the number of write-throughs still unacknowledged after this cycle, the flush is complete: flush-done is raised and the increment is taken back. A flush of a dirty line makes no check. It counts as one more issued write-through, and its acknowledge later makes the check. When both counters are zero at a check, the flag drops.

All updates are made on one clock edge. The counters, the flag and both pulses are registered. In any cycle, an acknowledge seen while the flag is set first lowers the phase counter, saturating at zero, and then takes the check.

Top module: `wt_flush_tracker`

## Requirements
- R1: After synchronous reset, wt_pending is 0, in_flush is 0, and flush_done and ack_underflow are both 0.
- R2: A cycle with wt_issue high and no acknowledge raises wt_pending by one on the next edge. A flush of a dirty line (flush_req and flush_dirty both high) adds one more.
- R3: A cycle with wb_ack high and no issue lowers wt_pending by one. If wt_pending is already 0, it stays 0 and ack_underflow is high for the following cycle.
- R4: When wt_issue and wb_ack are both high in one cycle, with no dirty flush, wt_pending does not change.
- R5: A clean-line flush while no write-through is outstanding raises flush_done in the next cycle, and in_flush stays 0.
- R6: A clean-line flush while N write-throughs are outstanding sets in_flush without flush_done. flush_done follows the acknowledge that brings wt_pending to 0, and not an earlier one.
- R7: A dirty-line flush sets in_flush and counts one write-through, with no flush_done. The acknowledge for that write-through raises flush_done.
- R8: flush_done is high for exactly one cycle per completion.
- R9: Acknowledges that arrive while in_flush is 0 never raise flush_done.
- R10: in_flush returns to 0 in the same cycle that flush_done rises when the last acknowledge drains both counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wt_issue | input | 1 | One write-through sent this cycle |
| wb_ack | input | 1 | One write acknowledge received this cycle |
| flush_req | input | 1 | Flush of one line this cycle |
| flush_dirty | input | 1 | The flushed line holds dirty data |
| flush_done | output | 1 | Release flush complete, one-cycle pulse |
| in_flush | output | 1 | A flush is open |
| wt_pending | output | CNT_W | Write-throughs still unacknowledged |
| ack_underflow | output | 1 | Acknowledge arrived with nothing outstanding |

## Verification
A wrong outstanding count shows on wt_pending on the edge after the faulty event. It also moves flush_done: a count that is too low fires completion one acknowledge early, and a count that is too high holds it back forever. A phase counter that is not restored after a completion, or a flag that does not clear, shows later. The next clean-line flush with no write-through outstanding then fails to give flush_done at once. The tests therefore chain flushes back to back, and every ack step checks in_flush and flush_done in the cycle after it.

// File: rtl/ftrk_pkg.sv
package ftrk_pkg;

    // Events decoded from the input pulses of one cycle
    typedef struct packed {
        logic [1:0] inc_n;   // write-throughs added this cycle (0..2)
        logic       dec;     // one acknowledge this cycle
        logic       arm;     // flush opens or keeps the flush window
        logic       check;   // completion check requested
    } ftrk_evt_t;

    // Saturating decrement by one
    function automatic logic [7:0] sat_dec8(input logic [7:0] v, input logic en);
        return (en && v != 8'd0) ? v - 8'd1 : v;
    endfunction

endpackage

// File: rtl/ftrk_event_decode.sv
module ftrk_event_decode
    import ftrk_pkg::*;
(
    input  logic      wt_issue,
    input  logic      wb_ack,
    input  logic      flush_req,
    input  logic      flush_dirty,
    output ftrk_evt_t evt
);
    logic dirty_flush;
    logic clean_flush;

    always_comb begin
        dirty_flush = flush_req & flush_dirty;
        clean_flush = flush_req & ~flush_dirty;
        evt.inc_n   = {1'b0, wt_issue} + {1'b0, dirty_flush};
        evt.dec     = wb_ack;
        evt.arm     = flush_req;
        evt.check   = wb_ack | clean_flush;
    end
endmodule

// File: rtl/ftrk_pending_ctr.sv
module ftrk_pending_ctr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       inc_n,
    input  logic             dec,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next,
    output logic             underflow_q
);
    logic dec_ok;
    logic underflow_d;

    always_comb begin
        dec_ok      = dec && (cnt_q != '0 || inc_n != 2'd0);
        underflow_d = dec && cnt_q == '0 && inc_n == 2'd0;
        cnt_next    = cnt_q + CNT_W'(inc_n) - CNT_W'(dec_ok);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            underflow_q <= 1'b0;
        end else begin
            cnt_q       <= cnt_next;
            underflow_q <= underflow_d;
        end
    end
endmodule

// File: rtl/ftrk_phase_unit.sv
module ftrk_phase_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             check,
    input  logic             ack,
    input  logic [CNT_W-1:0] pend_next,
    output logic             in_flush_q,
    output logic             done_q
);
    logic [CNT_W-1:0] phase_q;
    logic [CNT_W-1:0] phase_dn;
    logic [CNT_W:0]   phase_up;
    logic [CNT_W-1:0] phase_d;
    logic             flag_open;
    logic             do_check;
    logic             complete;
    logic             flag_d;

    always_comb begin
        flag_open = in_flush_q | arm;
        // acknowledge inside an open flush lowers the phase count first
        phase_dn  = (ack && in_flush_q && phase_q != '0) ? phase_q - 1'b1 : phase_q;
        do_check  = check & flag_open;
        phase_up  = {1'b0, phase_dn} + 1'b1;
        complete  = do_check && (phase_up > {1'b0, pend_next});
        if (do_check && !complete)
            phase_d = phase_up[CNT_W-1:0];
        else
            phase_d = phase_dn;
        flag_d = flag_open;
        if (do_check && pend_next == '0 && phase_d == '0)
            flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= '0;
            in_flush_q <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            phase_q    <= phase_d;
            in_flush_q <= flag_d;
            done_q     <= complete;
        end
    end
endmodule

// File: rtl/wt_flush_tracker.sv
module wt_flush_tracker
    import ftrk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wt_issue,
    input  logic             wb_ack,
    input  logic             flush_req,
    input  logic             flush_dirty,
    output logic             flush_done,
    output logic             in_flush,
    output logic [CNT_W-1:0] wt_pending,
    output logic             ack_underflow
);
    ftrk_evt_t        evt;
    logic [CNT_W-1:0] pend_next;

    ftrk_event_decode u_decode (
        .wt_issue   (wt_issue),
        .wb_ack     (wb_ack),
        .flush_req  (flush_req),
        .flush_dirty(flush_dirty),
        .evt        (evt)
    );

    ftrk_pending_ctr #(.CNT_W(CNT_W)) u_pending (
        .clk        (clk),
        .rst        (rst),
        .inc_n      (evt.inc_n),
        .dec        (evt.dec),
        .cnt_q      (wt_pending),
        .cnt_next   (pend_next),
        .underflow_q(ack_underflow)
    );

    ftrk_phase_unit #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst       (rst),
        .arm       (evt.arm),
        .check     (evt.check),
        .ack       (evt.dec),
        .pend_next (pend_next),
        .in_flush_q(in_flush),
        .done_q    (flush_done)
    );
endmodule

// File: rtl/wt_flush_tracker_chk.sv
module wt_flush_tracker_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             wt_issue,
    input logic             wb_ack,
    input logic             flush_req,
    input logic             flush_dirty,
    input logic             flush_done,
    input logic             in_flush,
    input logic [CNT_W-1:0] wt_pending,
    input logic             ack_underflow
);
    assert_issue_inc_R2: assert property (@(posedge clk) disable iff (rst)
        (wt_issue && !wb_ack && !flush_req && wt_pending != {CNT_W{1'b1}})
        |=> wt_pending == $past(wt_pending) + 1'b1);

    assert_underflow_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (wb_ack && !wt_issue && !flush_req && wt_pending == '0)
        |=> (ack_underflow && wt_pending == '0));

    assert_same_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (wt_issue && wb_ack && !(flush_req && flush_dirty)) |=> $stable(wt_pending));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !flush_done);

    assert_no_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!in_flush && !flush_req) |=> !flush_done);
endmodule

bind wt_flush_tracker wt_flush_tracker_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .wt_issue     (wt_issue),
    .wb_ack       (wb_ack),
    .flush_req    (flush_req),
    .flush_dirty  (flush_dirty),
    .flush_done   (flush_done),
    .in_flush     (in_flush),
    .wt_pending   (wt_pending),
    .ack_underflow(ack_underflow)
);

// File: tb/test_wt_flush_tracker.sv
module test_wt_flush_tracker;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wt_issue = 1'b0;
    logic             wb_ack = 1'b0;
    logic             flush_req = 1'b0;
    logic             flush_dirty = 1'b0;
    logic             flush_done;
    logic             in_flush;
    logic [CNT_W-1:0] wt_pending;
    logic             ack_underflow;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_flush_tracker #(.CNT_W(CNT_W)) i_wt_flush_tracker (
        .clk(clk), .rst(rst), .wt_issue(wt_issue), .wb_ack(wb_ack),
        .flush_req(flush_req), .flush_dirty(flush_dirty),
        .flush_done(flush_done), .in_flush(in_flush),
        .wt_pending(wt_pending), .ack_underflow(ack_underflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle of stimulus, driven after a falling edge; returns at the
    // next falling edge, when registered outputs reflect that cycle.
    task automatic step(input logic i, input logic a, input logic f, input logic d);
        wt_issue = i; wb_ack = a; flush_req = f; flush_dirty = d;
        @(negedge clk);
        wt_issue = 0; wb_ack = 0; flush_req = 0; flush_dirty = 0;
    endtask

    task automatic idle();
        step(0, 0, 0, 0);
    endtask

    task automatic t_reset();
        chk("R1 pending", wt_pending, 0);
        chk("R1 in_flush", in_flush, 0);
        chk("R1 done", flush_done, 0);
        chk("R1 underflow", ack_underflow, 0);
    endtask

    task automatic t_counting();
        step(1, 0, 0, 0); chk("R2 inc1", wt_pending, 1);
        step(1, 0, 0, 0); chk("R2 inc2", wt_pending, 2);
        step(1, 1, 0, 0); chk("R4 same cycle", wt_pending, 2);
        step(0, 1, 0, 0); chk("R3 dec", wt_pending, 1);
        chk("R9 ack outside flush", flush_done, 0);
        step(0, 1, 0, 0); chk("R3 dec to 0", wt_pending, 0);
        chk("R3 no underflow", ack_underflow, 0);
        step(0, 1, 0, 0); chk("R3 floor", wt_pending, 0);
        chk("R3 underflow flag", ack_underflow, 1);
        chk("R9 stray ack", flush_done, 0);
        idle(); chk("R3 underflow clears", ack_underflow, 0);
    endtask

    task automatic t_clean_empty();
        step(0, 0, 1, 0);
        chk("R5 done", flush_done, 1);
        chk("R5 in_flush", in_flush, 0);
        idle(); chk("R8 done one cycle", flush_done, 0);
    endtask

    task automatic t_clean_pending();
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        step(0, 0, 1, 0);
        chk("R6 in_flush set", in_flush, 1);
        chk("R6 no early done", flush_done, 0);
        step(0, 1, 0, 0);
        chk("R6 pending 1", wt_pending, 1);
        chk("R6 no done mid", flush_done, 0);
        chk("R6 still in flush", in_flush, 1);
        step(0, 1, 0, 0);
        chk("R6 done on last ack", flush_done, 1);
        chk("R10 in_flush clear", in_flush, 0);
        idle(); chk("R8 done dropped", flush_done, 0);
        t_clean_empty();
    endtask

    task automatic t_dirty();
        step(0, 0, 1, 1);
        chk("R7 counted", wt_pending, 1);
        chk("R7 in_flush", in_flush, 1);
        chk("R7 no done", flush_done, 0);
        step(1, 0, 0, 0);
        chk("R2 issue in flush", wt_pending, 2);
        step(0, 1, 0, 0);
        chk("R7 no done with one left", flush_done, 0);
        step(0, 1, 0, 0);
        chk("R7 done", flush_done, 1);
        chk("R10 flag cleared", in_flush, 0);
        chk("R7 pending 0", wt_pending, 0);
        idle(); chk("R8 single pulse", flush_done, 0);
        t_clean_empty();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_counting();
        t_clean_empty();
        t_clean_pending();
        t_dirty();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule